// File: doc/BRIEF.md
# Sector Erase Window Timer

This block tracks the accept window of a multi-sector erase in a NOR-flash-style command engine. A decoded sector-erase command opens a time-out window and marks its sector in a pending mask. While the window is open, further sector-erase commands add sectors to the mask and restart the time-out. When the time-out runs out with no new sector, the erase is considered started: the started flag rises and the mask is frozen. A decoded chip-erase command skips the window and starts at once with every sector marked. An erase-done pulse from the erase model ends the operation and clears everything. An erase in progress can be paused and continued with suspend and resume strobes. A reset command returns the block to read mode from any state.

Commands arrive on a valid/ready port. The block never applies back-pressure: `cmd_ready` follows `rst_n`, so every command offered outside reset is consumed in the cycle it is offered. A command that is not legal in the current state is consumed and dropped. The suspend, resume, reset and done strobes are plain single-cycle control inputs. Each accepted input takes effect on the outputs after the next rising clock edge.

Top module: `erase_window_top`

## Requirements
- R1: After `rst_n` is released, `busy`, `erase_active` and `suspended` are 0, `sector_mask` is all zero, and `cmd_ready` is 1.
- R2: In read mode, a command with `cmd_op` = 2'b01 (sector erase) and `cmd_sector` below NUM_SECTORS sets mask bit `cmd_sector` and raises `busy` on the next cycle, while `erase_active` stays 0.
- R3: `erase_active` rises exactly WINDOW_CYCLES clock edges after the edge that accepted the most recent sector-erase command, and stays 0 before that.
- R4: While `busy` is 1 and `erase_active` is 0, each valid in-range sector-erase command ORs one more bit into the mask and restarts the full window.
- R5: While `erase_active` is 1, sector-erase and chip-erase commands are ignored: the mask and `erase_active` do not change.
- R6: In read mode, a command with `cmd_op` = 2'b10 (chip erase) sets every mask bit and raises `busy` and `erase_active` on the next cycle, with no window. A chip erase that arrives while the window is open is ignored.
- R7: An `erase_done` pulse while `erase_active` is 1 and `suspended` is 0 clears the mask, `busy` and `erase_active` on the next cycle. It wins over a `suspend_req` in the same cycle. `erase_done` has no effect while the window is open or while suspended.
- R8: `suspend_req` while the erase runs sets `suspended` on the next cycle, and `resume_req` while suspended clears it. `erase_active` stays 1 throughout. `suspend_req` during the window, and `resume_req` when not suspended, have no effect.
- R9: `reset_cmd` clears `busy`, `erase_active`, `suspended` and the mask on the next cycle from any state, and any command offered in the same cycle is ignored.
- R10: Commands with `cmd_op` of 2'b00 or 2'b11, and sector-erase commands with `cmd_sector` at or above NUM_SECTORS, change nothing. `cmd_ready` equals `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command consumed; equals rst_n |
| cmd_op | input | 2 | 01 sector erase, 10 chip erase, others no operation |
| cmd_sector | input | SECT_W (6) | Sector index for a sector erase |
| suspend_req | input | 1 | Pause a running erase |
| resume_req | input | 1 | Continue a paused erase |
| reset_cmd | input | 1 | Return to read mode |
| erase_done | input | 1 | Erase model finished |
| erase_active | output | 1 | Window closed, erase started |
| sector_mask | output | NUM_SECTORS (35) | Sectors marked for erase |
| busy | output | 1 | Erase accepted and not yet finished |
| suspended | output | 1 | Running erase is paused |

## Verification
The bench keeps the default 35-sector mask, so the top sector index and the first out-of-range indices (35 up to 63 in the six-bit field) are both reachable. It shortens the window to 12 cycles. With that window, the exact expiry edge, restarts at the last cycle of the window and long random runs with many complete erase cycles fit in a short simulation. The random phase mixes commands, strobes and resets so that same-cycle collisions happen often: a restart against expiry, done against suspend, and reset against everything.

// File: rtl/sew_pkg.sv
package sew_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_SECTOR = 2'b01,
    OP_CHIP   = 2'b10,
    OP_RSVD   = 2'b11
  } sew_op_e;

  typedef enum logic [1:0] {
    ST_READ    = 2'b00,
    ST_WINDOW  = 2'b01,
    ST_ERASING = 2'b10,
    ST_PAUSED  = 2'b11
  } sew_state_e;

endpackage

// File: rtl/sew_cmd_decode.sv
module sew_cmd_decode #(
  parameter int NUM_SECTORS = 35,
  parameter int SECT_W      = 6
) (
  input  logic                   cmd_fire,
  input  logic [1:0]             cmd_op,
  input  logic [SECT_W-1:0]      cmd_sector,
  output logic                   sect_hit,
  output logic                   chip_hit,
  output logic [NUM_SECTORS-1:0] sect_onehot
);
  import sew_pkg::*;

  localparam logic [SECT_W:0] LIMIT = (SECT_W+1)'(NUM_SECTORS);

  logic in_range;

  assign in_range = ({1'b0, cmd_sector} < LIMIT);
  assign sect_hit = cmd_fire && (cmd_op == OP_SECTOR) && in_range;
  assign chip_hit = cmd_fire && (cmd_op == OP_CHIP);

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_dec
    assign sect_onehot[i] = (cmd_sector == SECT_W'(i));
  end

endmodule

// File: rtl/sew_window_timer.sv
module sew_window_timer #(
  parameter int WINDOW_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // The window closes on a cycle that brings no restart.
  assign expired = run && !load && (cnt_q == '0);

endmodule

// File: rtl/sew_erase_fsm.sv
module sew_erase_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reset_cmd,
  input  logic                sect_hit,
  input  logic                chip_hit,
  input  logic                window_expired,
  input  logic                suspend_req,
  input  logic                resume_req,
  input  logic                erase_done,
  output sew_pkg::sew_state_e state,
  output logic                sect_accept,
  output logic                chip_accept,
  output logic                done_accept
);
  import sew_pkg::*;

  sew_state_e state_q, state_d;

  assign sect_accept = sect_hit && !reset_cmd &&
                       ((state_q == ST_READ) || (state_q == ST_WINDOW));
  assign chip_accept = chip_hit && !reset_cmd && (state_q == ST_READ);
  assign done_accept = erase_done && !reset_cmd && (state_q == ST_ERASING);

  always_comb begin
    state_d = state_q;
    if (reset_cmd) begin
      state_d = ST_READ;
    end else begin
      unique case (state_q)
        ST_READ: begin
          if (chip_accept)      state_d = ST_ERASING;
          else if (sect_accept) state_d = ST_WINDOW;
        end
        ST_WINDOW: begin
          if (window_expired)   state_d = ST_ERASING;
        end
        ST_ERASING: begin
          if (done_accept)      state_d = ST_READ;
          else if (suspend_req) state_d = ST_PAUSED;
        end
        ST_PAUSED: begin
          if (resume_req)       state_d = ST_ERASING;
        end
        default:                state_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_READ;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/sew_sector_mask.sv
module sew_sector_mask #(
  parameter int NUM_SECTORS = 35
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   set_all,
  input  logic                   set_en,
  input  logic [NUM_SECTORS-1:0] set_vec,
  output logic [NUM_SECTORS-1:0] mask
);
  logic [NUM_SECTORS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (clear) begin
      mask_q <= '0;
    end else if (set_all) begin
      mask_q <= '1;
    end else if (set_en) begin
      mask_q <= mask_q | set_vec;
    end
  end

  assign mask = mask_q;

endmodule

// File: rtl/erase_window_top.sv
module erase_window_top #(
  parameter int NUM_SECTORS   = 35,
  parameter int WINDOW_CYCLES = 50,
  parameter int SECT_W        = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [1:0]             cmd_op,
  input  logic [SECT_W-1:0]      cmd_sector,
  input  logic                   suspend_req,
  input  logic                   resume_req,
  input  logic                   reset_cmd,
  input  logic                   erase_done,
  output logic                   erase_active,
  output logic [NUM_SECTORS-1:0] sector_mask,
  output logic                   busy,
  output logic                   suspended
);
  import sew_pkg::*;

  logic                   cmd_fire;
  logic                   sect_hit, chip_hit;
  logic [NUM_SECTORS-1:0] sect_onehot;
  logic                   sect_accept, chip_accept, done_accept;
  logic                   window_expired;
  sew_state_e             state;

  // Never stalls: commands are consumed whenever out of reset.
  assign cmd_ready = rst_n;
  assign cmd_fire  = cmd_valid && cmd_ready;

  sew_cmd_decode #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECT_W      (SECT_W)
  ) u_decode (
    .cmd_fire    (cmd_fire),
    .cmd_op      (cmd_op),
    .cmd_sector  (cmd_sector),
    .sect_hit    (sect_hit),
    .chip_hit    (chip_hit),
    .sect_onehot (sect_onehot)
  );

  sew_erase_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .reset_cmd      (reset_cmd),
    .sect_hit       (sect_hit),
    .chip_hit       (chip_hit),
    .window_expired (window_expired),
    .suspend_req    (suspend_req),
    .resume_req     (resume_req),
    .erase_done     (erase_done),
    .state          (state),
    .sect_accept    (sect_accept),
    .chip_accept    (chip_accept),
    .done_accept    (done_accept)
  );

  sew_window_timer #(
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (reset_cmd),
    .load    (sect_accept),
    .run     (state == ST_WINDOW),
    .expired (window_expired)
  );

  sew_sector_mask #(
    .NUM_SECTORS (NUM_SECTORS)
  ) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (reset_cmd || done_accept),
    .set_all (chip_accept),
    .set_en  (sect_accept),
    .set_vec (sect_onehot),
    .mask    (sector_mask)
  );

  assign busy         = (state != ST_READ);
  assign erase_active = (state == ST_ERASING) || (state == ST_PAUSED);
  assign suspended    = (state == ST_PAUSED);

endmodule

// File: rtl/erase_window_chk.sv
module erase_window_chk #(
  parameter int NUM_SECTORS   = 35,
  parameter int WINDOW_CYCLES = 50,
  parameter int SECT_W        = $clog2(NUM_SECTORS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic [1:0]             cmd_op,
  input logic [SECT_W-1:0]      cmd_sector,
  input logic                   suspend_req,
  input logic                   resume_req,
  input logic                   reset_cmd,
  input logic                   erase_done,
  input logic                   erase_active,
  input logic [NUM_SECTORS-1:0] sector_mask,
  input logic                   busy,
  input logic                   suspended
);
  import sew_pkg::*;

  localparam int WC_W = $clog2(WINDOW_CYCLES + 2);
  localparam logic [SECT_W:0] LIMIT = (SECT_W+1)'(NUM_SECTORS);

  logic            fire, sect_cmd, chip_cmd, oob_cmd;
  logic [WC_W-1:0] open_cnt;

  assign fire     = cmd_valid && cmd_ready;
  assign sect_cmd = fire && (cmd_op == OP_SECTOR) && ({1'b0, cmd_sector} < LIMIT);
  assign chip_cmd = fire && (cmd_op == OP_CHIP);
  assign oob_cmd  = fire && (cmd_op == OP_SECTOR) && !({1'b0, cmd_sector} < LIMIT);

  // Cycles spent with the window open since the last accepted sector.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             open_cnt <= '0;
    else if (!busy || erase_active || sect_cmd) open_cnt <= '0;
    else if (open_cnt != '1)                open_cnt <= open_cnt + 1'b1;
  end

  // R1
  idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sector_mask == '0 && !erase_active && !suspended));

  // R2
  first_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sect_cmd && !reset_cmd) |=> (busy && !erase_active && sector_mask != '0));

  // R3
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_active) |-> (open_cnt < WC_W'(WINDOW_CYCLES)));

  // R4
  window_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_active && sect_cmd && !reset_cmd) |=>
      (!erase_active && $countones(sector_mask) >= $past($countones(sector_mask))));

  // R5
  frozen_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && !reset_cmd && !(erase_done && !suspended)) |=>
      ($stable(sector_mask) && erase_active));

  // R6
  chip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && chip_cmd && !reset_cmd) |=> (erase_active && (&sector_mask)));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && !suspended && erase_done && !reset_cmd) |=> (!busy && sector_mask == '0));

  // R8
  suspend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && !suspended && suspend_req && !erase_done && !reset_cmd) |=> suspended);

  // R8
  resume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && resume_req && !reset_cmd) |=> (!suspended && erase_active));

  // R8
  pause_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (erase_active && busy));

  // R9
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (!busy && !erase_active && !suspended && sector_mask == '0));

  // R10
  oob_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && oob_cmd && !reset_cmd) |=> !busy);

  // R10
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready);

endmodule

bind erase_window_top erase_window_chk #(
  .NUM_SECTORS   (NUM_SECTORS),
  .WINDOW_CYCLES (WINDOW_CYCLES),
  .SECT_W        (SECT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_op       (cmd_op),
  .cmd_sector   (cmd_sector),
  .suspend_req  (suspend_req),
  .resume_req   (resume_req),
  .reset_cmd    (reset_cmd),
  .erase_done   (erase_done),
  .erase_active (erase_active),
  .sector_mask  (sector_mask),
  .busy         (busy),
  .suspended    (suspended)
);

// File: tb/erase_window_top_bench.sv
`timescale 1ns/1ps
module erase_window_top_bench;
  localparam int NS = 35;
  localparam int WC = 12;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [SW-1:0] cmd_sector = '0;
  logic          suspend_req = 1'b0, resume_req = 1'b0, reset_cmd = 1'b0, erase_done = 1'b0;
  logic          cmd_ready, erase_active, busy, suspended;
  logic [NS-1:0] sector_mask;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit fin = 0;

  // expected-state model
  bit          m_busy, m_act, m_susp;
  bit [NS-1:0] m_mask;
  int          m_win;

  always #2 clk = ~clk;

  erase_window_top #(.NUM_SECTORS(NS), .WINDOW_CYCLES(WC)) u_erase_window_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sector(cmd_sector), .suspend_req(suspend_req),
    .resume_req(resume_req), .reset_cmd(reset_cmd), .erase_done(erase_done),
    .erase_active(erase_active), .sector_mask(sector_mask), .busy(busy),
    .suspended(suspended));

  function automatic bit sect_ok(logic [1:0] op, logic [SW-1:0] s);
    return (op == 2'b01) && (int'(s) < NS);
  endfunction

  task automatic model_step();
    bit sv = cmd_valid && sect_ok(cmd_op, cmd_sector);
    bit cv = cmd_valid && (cmd_op == 2'b10);
    if (reset_cmd) begin
      m_busy = 0; m_act = 0; m_susp = 0; m_mask = '0; m_win = 0;
    end else if (!m_busy) begin
      if (sv) begin m_mask[cmd_sector] = 1'b1; m_busy = 1; m_win = WC; end
      else if (cv) begin m_mask = '1; m_busy = 1; m_act = 1; end
    end else if (!m_act) begin
      if (sv) begin m_mask[cmd_sector] = 1'b1; m_win = WC; end
      else begin m_win--; if (m_win == 0) m_act = 1; end
    end else if (m_susp) begin
      if (resume_req) m_susp = 0;
    end else begin
      if (erase_done) begin m_busy = 0; m_act = 0; m_mask = '0; end
      else if (suspend_req) m_susp = 1;
    end
  endtask

  task automatic check(string tag, string nm, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    check(tag, "busy", 64'(busy), 64'(m_busy));
    check(tag, "erase_active", 64'(erase_active), 64'(m_act));
    check(tag, "suspended", 64'(suspended), 64'(m_susp));
    check(tag, "sector_mask", 64'(sector_mask), 64'(m_mask));
    check(tag, "cmd_ready", 64'(cmd_ready), 64'(1));
  endtask

  task automatic set_in(bit v, logic [1:0] op, int sec, bit sp, bit rs, bit rc, bit dn);
    cmd_valid = v; cmd_op = op; cmd_sector = SW'(sec);
    suspend_req = sp; resume_req = rs; reset_cmd = rc; erase_done = dn;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_all(tag);
    set_in(0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !fin) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d (expected finish)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_busy = 0; m_act = 0; m_susp = 0; m_mask = '0; m_win = 0;
    repeat (3) @(negedge clk);
    check("R10", "cmd_ready_in_reset", 64'(cmd_ready), 64'(0));
    rst_n = 1'b1;
    #1;
    cmp_all("R1");

    // R2 / R3: single sector, exact window boundary
    set_in(1, 2'b01, 5, 0, 0, 0, 0); step("R2");
    idle("R3", WC - 1);
    check("R3", "active_before_expiry", 64'(erase_active), 64'(0));
    step("R3");
    check("R3", "active_at_expiry", 64'(erase_active), 64'(1));
    // R5: commands ignored once started
    set_in(1, 2'b01, 9, 0, 0, 0, 0); step("R5");
    set_in(1, 2'b10, 0, 0, 0, 0, 0); step("R5");
    check("R5", "mask_frozen", 64'(sector_mask), 64'(1) << 5);
    set_in(0, 2'b00, 0, 0, 0, 0, 1); step("R7");

    // R4: window grows, restart on the last window cycle, edge sectors
    set_in(1, 2'b01, 0, 0, 0, 0, 0); step("R4");
    set_in(0, 2'b00, 0, 0, 0, 0, 1); step("R7");  // done ignored in window
    set_in(1, 2'b10, 0, 0, 0, 0, 0); step("R6");  // chip ignored in window
    set_in(0, 2'b00, 0, 1, 0, 0, 0); step("R8");  // suspend ignored in window
    idle("R4", WC - 4);
    set_in(1, 2'b01, NS - 1, 0, 0, 0, 0); step("R4");
    set_in(1, 2'b01, 40, 0, 0, 0, 0); step("R10");
    set_in(1, 2'b11, 3, 0, 0, 0, 0); step("R10");
    idle("R4", WC - 3);
    check("R4", "still_open", 64'(erase_active), 64'(0));
    check("R4", "mask_edges", 64'(sector_mask), (64'(1) << (NS - 1)) | 64'(1));
    step("R3");
    check("R3", "restarted_expiry", 64'(erase_active), 64'(1));

    // R8: suspend, done ignored, resume, then done+suspend collision
    set_in(0, 2'b00, 0, 1, 0, 0, 0); step("R8");
    set_in(0, 2'b00, 0, 0, 0, 0, 1); step("R8");
    check("R8", "done_ignored_paused", 64'(busy), 64'(1));
    set_in(0, 2'b00, 0, 0, 1, 0, 0); step("R8");
    set_in(0, 2'b00, 0, 1, 0, 0, 1); step("R7");
    check("R7", "done_wins", 64'(busy), 64'(0));

    // R6: chip erase with no window
    set_in(1, 2'b10, 0, 0, 0, 0, 0); step("R6");
    check("R6", "all_sectors", 64'(sector_mask), 64'((65'(1) << NS) - 1));
    set_in(0, 2'b00, 0, 0, 0, 0, 1); step("R7");

    // R10: no-ops and out of range from read mode
    set_in(1, 2'b00, 1, 0, 0, 0, 0); step("R10");
    set_in(1, 2'b01, NS, 0, 0, 0, 0); step("R10");
    set_in(1, 2'b01, 63, 0, 0, 0, 0); step("R10");
    check("R10", "still_idle", 64'(busy), 64'(0));

    // R9: reset in window (with a colliding command) and while paused
    set_in(1, 2'b01, 7, 0, 0, 0, 0); step("R9");
    set_in(1, 2'b01, 8, 0, 0, 1, 0); step("R9");
    check("R9", "reset_window", 64'(sector_mask), 64'(0));
    set_in(1, 2'b10, 0, 0, 0, 0, 0); step("R9");
    set_in(0, 2'b00, 0, 1, 0, 0, 0); step("R9");
    set_in(0, 2'b00, 0, 0, 0, 1, 0); step("R9");
    check("R9", "reset_paused", 64'(suspended), 64'(0));

    // random phase
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom_range(99, 0));
      logic [1:0] op = (r < 60) ? 2'b01 : (r < 75) ? 2'b10 : 2'($urandom_range(3, 0));
      set_in($urandom_range(99, 0) < 25, op, int'($urandom_range(40, 0)),
             $urandom_range(99, 0) < 5, $urandom_range(99, 0) < 10,
             $urandom_range(999, 0) < 8, $urandom_range(99, 0) < 6);
      step("random R4/R5/R7/R8");
    end

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule